// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write front end of a paged nonvolatile memory. A host issues write strobes through an active-low chip select and an active-low write enable. Each strobe carries a 15-bit address and a data word. The upper address bits name a page. The lowest six bits pick one of 64 word slots in that page. The controller latches the page from the first accepted strobe and stores each word in a page buffer. It keeps a mask of the slots that were written.

Each accepted strobe restarts a load-window timer. If the timer reaches its limit and no strobe is in progress, the controller stops taking loads and raises busy for a fixed programming time. During that time, the storage array beside it reads the page number, the slot mask and the buffered words. When programming ends, busy drops and a single-cycle done pulse follows. The mask is then cleared for the next page.

Strobes that name a different page during the load window are dropped and raise a sticky error. Strobes that start while busy or done is high are dropped without any error.

Top module: `pageLoadCtrl`

## Requirements
- R1: After reset, busy, done and pageErr are low and loadMask is all zero.
- R2: A strobe is active while csN and weN are both low. The address is taken in the first clock where both are low. The data is the value seen in the last clock where both are low. The word is stored at the clock edge where either strobe has gone high.
- R3: The first accepted strobe after idle fixes the page to addr[14:6], and progPage shows it. Every strobe uses addr[5:0] as the slot index.
- R4: A strobe that starts during the load window with addr[14:6] different from the latched page is dropped. It stores nothing, sets no mask bit and does not restart the window timer. It sets pageErr, which stays high until reset.
- R5: One programming cycle carries 1 to 64 words, loaded in any slot order. A slot written twice keeps the later data.
- R6: loadMask bit i is high exactly when slot i was loaded in the current page. loadMask does not change while busy is high.
- R7: Busy rises at the clock edge LOAD_WINDOW+1 cycles after the edge that sampled the start of the last accepted strobe, provided no strobe is active then.
- R8: Busy stays high for exactly PROG_CYCLES cycles. The next cycle has done high and busy low. In the cycle after that, done is low and loadMask is all zero.
- R9: A strobe that starts while busy or done is high has no effect: no busy follows and loadMask stays zero.
- R10: progData shows, without a clock delay, the buffered word of the slot selected by progIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Host chip select, active low |
| weN | input | 1 | Host write enable, active low |
| addr | input | ADDR_W (15) | Host address: page in [14:6], slot in [5:0] |
| dataIn | input | DATA_W (32) | Host write data |
| progIdx | input | IDX_W (6) | Slot selected for readout by the array |
| progData | output | DATA_W (32) | Buffered word of slot progIdx |
| progPage | output | ADDR_W-IDX_W (9) | Latched page number |
| loadMask | output | 2**IDX_W (64) | One bit per slot that was loaded |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-cycle pulse when programming ends |
| pageErr | output | 1 | Sticky flag for a dropped wrong-page strobe |

## Verification
The embedded properties watch the rules that hold in every cycle:
- busy and done are never high together, and done lasts one cycle;
- the window timer and the programming counter stay within their limits;
- pageErr never falls once set;
- loadMask is frozen while busy and is nonzero after a store.

Only the bench scenarios can show the rest: that the right words reach the right slots, that a later write to a slot wins, and where the address and data capture points fall when the two strobes split. The same holds for busy starting exactly one window after the last accepted start, that start not moving when a wrong-page strobe arrives, and strobes during programming leaving no trace.

// File: rtl/pageLoadPkg.sv
package pageLoadPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2,
    ST_DONE = 2'd3
  } ctlState_t;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic sampleData;  // strobe active: track the data word
    logic capAddr;     // accepted start: take the slot index
    logic latchPage;   // first accepted start: take the page
    logic writeWord;   // accepted strobe ended: store the word
    logic clearMask;   // programming finished: forget the page
  } dpStrobe_t;

endpackage

// File: rtl/pageLoadDp.sv
module pageLoadDp
  import pageLoadPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 15,
  parameter int IDX_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [IDX_W-1:0]        progIdx,
  output logic                    pageMatch,
  output logic [ADDR_W-IDX_W-1:0] progPage,
  output logic [(1<<IDX_W)-1:0]   loadMask,
  output logic [DATA_W-1:0]       progData
);

  localparam int WORDS  = 1 << IDX_W;
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idxQ;
  logic [PAGE_W-1:0] pageQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] bufMem [WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      pageQ <= '0;
      dataQ <= '0;
    end else begin
      if (strb.capAddr)    idxQ  <= addr[IDX_W-1:0];
      if (strb.latchPage)  pageQ <= addr[ADDR_W-1:IDX_W];
      if (strb.sampleData) dataQ <= dataIn;
    end
  end

  // one storage slot and one mask bit per word of the page
  for (genvar i = 0; i < WORDS; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        loadMask[i] <= 1'b0;
        bufMem[i]   <= '0;
      end else if (strb.clearMask) begin
        loadMask[i] <= 1'b0;
      end else if (strb.writeWord && idxQ == IDX_W'(i)) begin
        loadMask[i] <= 1'b1;
        bufMem[i]   <= dataQ;
      end
    end
  end

  assign pageMatch = (addr[ADDR_W-1:IDX_W] == pageQ);
  assign progPage  = pageQ;
  assign progData  = bufMem[progIdx];

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeWord && !strb.clearMask) |=> (loadMask != '0)); // R6

endmodule

// File: rtl/pageLoadCtl.sv
module pageLoadCtl
  import pageLoadPkg::*;
#(
  parameter int LOAD_WINDOW = 7500,
  parameter int PROG_CYCLES = 150000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      strobeAct,
  input  logic      pageMatch,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      done,
  output logic      pageErr
);

  localparam int TMR_W = $clog2(LOAD_WINDOW + 1);
  localparam int PRG_W = $clog2(PROG_CYCLES + 1);

  ctlState_t  state;
  logic       actQ;
  logic       acceptQ;
  logic [TMR_W-1:0] timer;
  logic [PRG_W-1:0] progCnt;

  logic startEdge, endEdge, isIdle, isLoad, acceptNow, rejectNow, expire, progEnd;

  always_comb begin
    startEdge = strobeAct && !actQ;
    endEdge   = !strobeAct && actQ;
    isIdle    = (state == ST_IDLE);
    isLoad    = (state == ST_LOAD);
    acceptNow = startEdge && (isIdle || (isLoad && pageMatch));
    rejectNow = startEdge && isLoad && !pageMatch;
    expire    = isLoad && (timer == TMR_W'(LOAD_WINDOW)) && !strobeAct && !acceptQ;
    progEnd   = (state == ST_PROG) && (progCnt == PRG_W'(PROG_CYCLES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      actQ    <= 1'b0;
      acceptQ <= 1'b0;
      timer   <= '0;
      progCnt <= '0;
      pageErr <= 1'b0;
    end else begin
      actQ <= strobeAct;
      if (acceptNow)    acceptQ <= 1'b1;
      else if (endEdge) acceptQ <= 1'b0;
      if (rejectNow) pageErr <= 1'b1;

      if (acceptNow) timer <= '0;
      else if (isLoad && timer != TMR_W'(LOAD_WINDOW)) timer <= timer + 1'b1;

      if (expire) progCnt <= '0;
      else if (state == ST_PROG) progCnt <= progCnt + 1'b1;

      unique case (state)
        ST_IDLE: if (acceptNow) state <= ST_LOAD;
        ST_LOAD: if (expire) state <= ST_PROG;
        ST_PROG: if (progEnd) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.sampleData = strobeAct;
    strb.capAddr    = acceptNow;
    strb.latchPage  = acceptNow && isIdle;
    strb.writeWord  = endEdge && acceptQ;
    strb.clearMask  = (state == ST_DONE);
  end

  assign busy = (state == ST_PROG);
  assign done = (state == ST_DONE);

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R8
  AST_PROG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (progCnt < PRG_W'(PROG_CYCLES))); // R8
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMR_W'(LOAD_WINDOW)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |=> pageErr); // R4

endmodule

// File: rtl/pageLoadCtrl.sv
module pageLoadCtrl
  import pageLoadPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 15,
  parameter int IDX_W       = 6,
  parameter int LOAD_WINDOW = 7500,
  parameter int PROG_CYCLES = 150000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    csN,
  input  logic                    weN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [IDX_W-1:0]        progIdx,
  output logic [DATA_W-1:0]       progData,
  output logic [ADDR_W-IDX_W-1:0] progPage,
  output logic [(1<<IDX_W)-1:0]   loadMask,
  output logic                    busy,
  output logic                    done,
  output logic                    pageErr
);

  dpStrobe_t strb;
  logic      strobeAct;
  logic      pageMatch;

  assign strobeAct = !csN && !weN;

  pageLoadCtl #(
    .LOAD_WINDOW(LOAD_WINDOW),
    .PROG_CYCLES(PROG_CYCLES)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .strobeAct(strobeAct),
    .pageMatch(pageMatch),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .pageErr  (pageErr)
  );

  pageLoadDp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .dataIn   (dataIn),
    .progIdx  (progIdx),
    .pageMatch(pageMatch),
    .progPage (progPage),
    .loadMask (loadMask),
    .progData (progData)
  );

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(loadMask)); // R6

endmodule

// File: tb/sim_pageLoadCtrl.sv
`timescale 1ns/1ps
module sim_pageLoadCtrl;

  localparam int WIN  = 40;
  localparam int PROG = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, weN = 1'b1;
  logic [14:0] addr = '0;
  logic [31:0] dataIn = '0;
  logic [5:0]  progIdx = '0;
  logic [31:0] progData;
  logic [8:0]  progPage;
  logic [63:0] loadMask;
  logic        busy, done, pageErr;

  always #10 clk = ~clk;

  pageLoadCtrl #(.LOAD_WINDOW(WIN), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .addr(addr), .dataIn(dataIn),
    .progIdx(progIdx), .progData(progData), .progPage(progPage),
    .loadMask(loadMask), .busy(busy), .done(done), .pageErr(pageErr));

  typedef struct {
    logic [8:0]        page;
    logic [63:0]       mask;
    logic [63:0][31:0] data;
    int                startCyc;
  } exp_t;

  exp_t q[$];
  int   checks = 0, failures = 0, cyc = 0, completions = 0, target = 0;
  bit   finished = 0;

  logic [8:0]        mPage;
  logic [63:0]       mMask;
  logic [63:0][31:0] mData;
  bit                mOpen = 0;
  int                mStart;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic modelLoad(input logic [14:0] a, input logic [31:0] d, input int st);
    if (!mOpen) begin mOpen = 1; mPage = a[14:6]; mMask = '0; end
    if (a[14:6] == mPage) begin
      mMask[a[5:0]] = 1'b1;
      mData[a[5:0]] = d;
      mStart = st;
    end
  endtask

  // plain strobe: both low for three clocks, then released
  task automatic doLoad(input logic [14:0] a, input logic [31:0] d, input bit model);
    @(negedge clk);
    csN = 0; weN = 0; addr = a; dataIn = d;
    if (model) modelLoad(a, d, cyc);
    repeat (3) @(negedge clk);
    csN = 1; weN = 1;
    @(negedge clk);
  endtask

  task automatic endBurst();
    exp_t e;
    e.page = mPage; e.mask = mMask; e.data = mData; e.startCyc = mStart;
    q.push_back(e);
    mOpen = 0;
    target++;
    wait (completions == target);
  endtask

  // monitor: scoreboard compare when a programming cycle begins
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && busy) begin
        exp_t e;
        int n, bad;
        if (q.size() == 0) begin
          chk(0, "R7", "unexpected busy", 64'(busy), 64'(0));
        end else begin
          e = q.pop_front();
          chk(cyc - e.startCyc == WIN + 2, "R7", "window expiry cycle",
              64'(cyc - e.startCyc), 64'(WIN + 2));
          chk(progPage == e.page, "R3", "progPage", 64'(progPage), 64'(e.page));
          chk(loadMask == e.mask, "R6", "loadMask", loadMask, e.mask);
          n = 0; bad = 0;
          while (busy) begin
            if (n < 64) begin
              progIdx = 6'(n);
              #1;
              if (e.mask[n] && progData !== e.data[n]) begin
                bad++;
                chk(0, "R5", "word data", 64'(progData), 64'(e.data[n]));
              end
            end
            n++;
            @(negedge clk);
          end
          chk(n == PROG, "R8", "busy length", 64'(n), 64'(PROG));
          chk(bad == 0 && e.mask != 0, "R10", "buffer readout", 64'(bad), 64'(0));
          chk(done === 1'b1, "R8", "done after busy", 64'(done), 64'(1));
          @(negedge clk);
          chk(!done && !busy && loadMask == '0, "R8", "idle after done",
              {62'(loadMask != 0), done, busy}, 64'(0));
          completions++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !pageErr && loadMask == '0, "R1", "reset state",
        {loadMask != 0, pageErr, done, busy}, 64'(0));

    // R5 single-word page
    doLoad({9'h048, 6'h34}, 32'hCAFE0001, 1);
    endBurst();

    // R5 full page in reverse order
    for (int i = 63; i >= 0; i--) doLoad({9'h005, 6'(i)}, 32'hA5000000 + 32'(i * 7), 1);
    endBurst();

    // R5 rewrite of one slot: later data wins
    doLoad({9'h011, 6'h03}, 32'h11111111, 1);
    doLoad({9'h011, 6'h07}, 32'h22222222, 1);
    doLoad({9'h011, 6'h03}, 32'h33333333, 1);
    endBurst();

    // R4 wrong page last: dropped, no timer restart, flag set
    doLoad({9'h009, 6'h01}, 32'h90000001, 1);
    doLoad({9'h009, 6'h04}, 32'h90000004, 1);
    chk(pageErr == 1'b0, "R4", "no error before mismatch", 64'(pageErr), 64'(0));
    doLoad({9'h00A, 6'h02}, 32'hBAD00002, 0);
    chk(pageErr == 1'b1, "R4", "error after mismatch", 64'(pageErr), 64'(1));
    endBurst();

    // R9 strobe during busy is dropped
    doLoad({9'h003, 6'h3F}, 32'h0000FFFF, 1);
    q.push_back('{page: mPage, mask: mMask, data: mData, startCyc: mStart});
    mOpen = 0;
    target++;
    wait (busy);
    doLoad({9'h003, 6'h10}, 32'hDEADBEEF, 0);
    wait (completions == target);
    repeat (WIN + 20) @(negedge clk);
    chk(!busy && loadMask == '0, "R9", "busy-time strobe has no effect",
        {loadMask != 0, busy}, 64'(0));

    // R2 split strobes: address at later fall, data at earlier rise
    @(negedge clk);
    csN = 0; addr = {9'h0F0, 6'h01}; dataIn = 32'h0;
    @(negedge clk);
    weN = 0; addr = {9'h0F0, 6'h2A}; dataIn = 32'h12340001;
    modelLoad({9'h0F0, 6'h2A}, 32'h12340002, cyc);
    @(negedge clk);
    dataIn = 32'h12340002; addr = {9'h0F0, 6'h15};
    @(negedge clk);
    csN = 1; dataIn = 32'h12340003;
    @(negedge clk);
    weN = 1; dataIn = 32'h12340004;
    @(negedge clk);
    chk(loadMask == (64'd1 << 42), "R2", "slot from later falling edge",
        loadMask, 64'd1 << 42);
    endBurst();

    // R4 flag stays set across later pages
    chk(pageErr == 1'b1, "R4", "sticky error", 64'(pageErr), 64'(1));
    report();
  end

endmodule